// File: doc/BRIEF.md
# Transmit FIFO Watermark and Control-Word Status Unit

This block produces the status flags, the transfer request and the interrupt line for a serial port with a transmit data FIFO and a single receive control-word register. It keeps a registered count of free transmit FIFO entries, driven by push and pop strobes from the FIFO. It compares that count against a programmable watermark and raises a transmit transfer request while more entries are free than the watermark allows. Each DMA write to the transmit data port drops the request for one cycle. The request comes back on the following cycle only if the free-space condition still holds.

On the receive side, a load strobe captures a control word and sets a ready flag. A word that arrives while the flag is set overwrites the stored one. A read strobe clears the flag. Both flags are masked by their own interrupt enables and merged into one registered interrupt line. A status vector carries the two flags in its two lowest bits. Its other bits are always zero. The FIFO storage, the shifter and the bus decoder stay outside the block and appear only as strobes.

Top module: `sfsr_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `tx_free` = DEPTH (16), and `tx_req`, `rxc_rdy`, `irq`, `rxc_data` and `stat` are all zero.
- R2: `tx_free` changes on the same edge that samples a strobe. A lone `tx_push` lowers it by one, a lone `tx_pop` raises it by one, and a push together with a pop leaves it unchanged.
- R3: After an edge where `tx_en` was 1 and `dma_wr` was 0, `tx_req` is 1 exactly when the new `tx_free` is greater than the `wm` sampled at that edge. Equality gives 0.
- R4: After an edge with `dma_wr` high, `tx_req` is 0. On the next edge without `dma_wr`, it rises again if the condition of R3 holds. This also applies when a pop on the same edge makes the condition true.
- R5: After an edge where `tx_en` was 0, `tx_req` is 0 whatever the free count.
- R6: When `rx_en` is 1, `rxc_load` sets `rxc_rdy` and stores `rxc_word` into `rxc_data` on the same edge. A load while `rxc_rdy` is already 1 replaces the stored word and keeps the flag at 1.
- R7: `rxc_rd` without `rxc_load` clears `rxc_rdy` and leaves `rxc_data` unchanged. When both strobes come together, the load wins.
- R8: While `rx_en` is 0, `rxc_rdy` is forced to 0 and `rxc_load` is ignored: `rxc_data` keeps its value.
- R9: `irq` is registered. After each edge it equals (`tx_req` AND `ie_tx`) OR (`rxc_rdy` AND `ie_rx`), using the values held before that edge, so it follows a flag change one cycle later.
- R10: `stat` bit 0 is `tx_req`, bit 1 is `rxc_rdy`, and every higher bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wm | input | WM_W (4) | Free-entry watermark |
| tx_push | input | 1 | Entry written into the transmit FIFO |
| tx_pop | input | 1 | Entry taken from the transmit FIFO |
| dma_wr | input | 1 | DMA access to the transmit data port |
| rxc_load | input | 1 | New control word arriving |
| rxc_word | input | CW_W (16) | Arriving control word |
| rxc_rd | input | 1 | Read of the control-word register |
| ie_tx | input | 1 | Interrupt enable for the transmit request |
| ie_rx | input | 1 | Interrupt enable for control-word ready |
| tx_free | output | CNT_W (5) | Free transmit FIFO entries |
| tx_req | output | 1 | Transmit transfer request |
| rxc_data | output | CW_W (16) | Stored control word |
| rxc_rdy | output | 1 | Control word ready |
| stat | output | STAT_W (8) | Status vector |
| irq | output | 1 | Merged interrupt |

## Verification
The assertions assume that the FIFO never pushes while it is full and never pops while it is empty. Under that assumption the free count always stays between 0 and DEPTH, and each strobe moves it by exactly one. The bench keeps its own occupancy model and only issues strobes that this model allows. It also pairs a push with a pop only when the FIFO holds entries and is not full. All other inputs may change freely between edges. The bench changes them only at a fixed offset after the rising edge.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int FLAG_TX  = 0;
  localparam int FLAG_RX  = 1;
  localparam int N_FLAGS  = 2;

  typedef logic [N_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/sfsr_free_cnt.sv
module sfsr_free_cnt #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] free_q,
  output logic [CNT_W-1:0] free_nxt
);
  localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

  always_comb begin
    free_nxt = free_q;
    unique case ({push, pop})
      2'b10: if (free_q != '0)        free_nxt = free_q - 1'b1;
      2'b01: if (free_q != FULL_FREE) free_nxt = free_q + 1'b1;
      default: free_nxt = free_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= FULL_FREE;
    else     free_q <= free_nxt;
  end
endmodule

// File: rtl/sfsr_tx_req.sv
module sfsr_tx_req #(
  parameter int CNT_W = 5,
  parameter int WM_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             dma_wr,
  input  logic [WM_W-1:0]  wm,
  input  logic [CNT_W-1:0] free_nxt,
  output logic             req_q
);
  localparam int CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

  logic [CMP_W-1:0] free_ext;
  logic [CMP_W-1:0] wm_ext;
  logic             above;

  always_comb begin
    free_ext = CMP_W'(free_nxt);
    wm_ext   = CMP_W'(wm);
    above    = free_ext > wm_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= tx_en & above & ~dma_wr;
  end
endmodule

// File: rtl/sfsr_rxc_reg.sv
module sfsr_rxc_reg #(
  parameter int CW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_en,
  input  logic            load,
  input  logic [CW_W-1:0] word,
  input  logic            rd,
  output logic [CW_W-1:0] data_q,
  output logic            rdy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else if (!rx_en) begin
      rdy_q  <= 1'b0;
    end else if (load) begin
      data_q <= word;
      rdy_q  <= 1'b1;
    end else if (rd) begin
      rdy_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sfsr_irq_merge.sv
module sfsr_irq_merge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq_q
);
  logic [N-1:0] masked;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g] = flags[g] & enables[g];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/sfsr_top.sv
module sfsr_top #(
  parameter int DEPTH  = 16,
  parameter int WM_W   = 4,
  parameter int CW_W   = 16,
  parameter int STAT_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [WM_W-1:0]   wm,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              dma_wr,
  input  logic              rxc_load,
  input  logic [CW_W-1:0]   rxc_word,
  input  logic              rxc_rd,
  input  logic              ie_tx,
  input  logic              ie_rx,
  output logic [CNT_W-1:0]  tx_free,
  output logic              tx_req,
  output logic [CW_W-1:0]   rxc_data,
  output logic              rxc_rdy,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  import sfsr_pkg::*;

  logic [CNT_W-1:0] free_nxt;
  flag_vec_t        flags;
  flag_vec_t        ies;

  sfsr_free_cnt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
    .free_q(tx_free), .free_nxt(free_nxt)
  );

  sfsr_tx_req #(.CNT_W(CNT_W), .WM_W(WM_W)) u_req (
    .clk(clk), .rst(rst), .tx_en(tx_en), .dma_wr(dma_wr), .wm(wm),
    .free_nxt(free_nxt), .req_q(tx_req)
  );

  sfsr_rxc_reg #(.CW_W(CW_W)) u_rxc (
    .clk(clk), .rst(rst), .rx_en(rx_en), .load(rxc_load), .word(rxc_word),
    .rd(rxc_rd), .data_q(rxc_data), .rdy_q(rxc_rdy)
  );

  always_comb begin
    flags          = '0;
    flags[FLAG_TX] = tx_req;
    flags[FLAG_RX] = rxc_rdy;
    ies            = '0;
    ies[FLAG_TX]   = ie_tx;
    ies[FLAG_RX]   = ie_rx;
    stat           = STAT_W'(flags);
  end

  sfsr_irq_merge #(.N(N_FLAGS)) u_irq (
    .clk(clk), .rst(rst), .flags(flags), .enables(ies), .irq_q(irq)
  );
endmodule

// File: rtl/sfsr_top_chk.sv
module sfsr_top_chk #(
  parameter int DEPTH  = 16,
  parameter int WM_W   = 4,
  parameter int CW_W   = 16,
  parameter int STAT_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              rx_en,
  input logic [WM_W-1:0]   wm,
  input logic              tx_push,
  input logic              tx_pop,
  input logic              dma_wr,
  input logic              rxc_load,
  input logic [CW_W-1:0]   rxc_word,
  input logic              rxc_rd,
  input logic              ie_tx,
  input logic              ie_rx,
  input logic [CNT_W-1:0]  tx_free,
  input logic              tx_req,
  input logic [CW_W-1:0]   rxc_data,
  input logic              rxc_rdy,
  input logic [STAT_W-1:0] stat,
  input logic              irq
);
  logic pv;
  always_ff @(posedge clk) pv <= ~rst;

  // R2: input assumption, no push into a full FIFO
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_push && !tx_pop) |-> (tx_free != '0));

  // R2: a lone push lowers the free count by one
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(tx_push && !tx_pop)) |-> (tx_free == $past(tx_free) - 1'b1));

  // R3: request only above the watermark
  p_req_above_wm_r3: assert property (@(posedge clk) disable iff (rst)
    (pv && tx_req) |-> (CNT_W'(tx_free) > CNT_W'($past(wm))));

  // R4: DMA access clears the request
  p_dma_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(dma_wr)) |-> !tx_req);

  // R5: disabled transmit gives no request
  p_req_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(tx_en)) |-> !tx_req);

  // R6: load stores the word and sets ready
  p_load_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(rx_en && rxc_load)) |-> (rxc_rdy && rxc_data == $past(rxc_word)));

  // R7: read alone clears ready
  p_rd_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(rxc_rd && !rxc_load)) |-> !rxc_rdy);

  // R8: disabled receive keeps data
  p_rx_off_r8: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(rx_en)) |-> (!rxc_rdy && $stable(rxc_data)));

  // R9: interrupt follows enabled flags one cycle later
  p_irq_lag_r9: assert property (@(posedge clk) disable iff (rst)
    pv |-> (irq == (($past(tx_req) && $past(ie_tx)) || ($past(rxc_rdy) && $past(ie_rx)))));
endmodule

bind sfsr_top sfsr_top_chk #(
  .DEPTH(DEPTH), .WM_W(WM_W), .CW_W(CW_W), .STAT_W(STAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .wm(wm),
  .tx_push(tx_push), .tx_pop(tx_pop), .dma_wr(dma_wr),
  .rxc_load(rxc_load), .rxc_word(rxc_word), .rxc_rd(rxc_rd),
  .ie_tx(ie_tx), .ie_rx(ie_rx), .tx_free(tx_free), .tx_req(tx_req),
  .rxc_data(rxc_data), .rxc_rdy(rxc_rdy), .stat(stat), .irq(irq)
);

// File: tb/test_sfsr_top.sv
module test_sfsr_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WM_W = 4;
  localparam int CW_W = 16;
  localparam int STAT_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, rx_en = 0, tx_push = 0, tx_pop = 0, dma_wr = 0;
  logic rxc_load = 0, rxc_rd = 0, ie_tx = 0, ie_rx = 0;
  logic [WM_W-1:0] wm = '0;
  logic [CW_W-1:0] rxc_word = '0;
  logic [CNT_W-1:0] tx_free;
  logic tx_req, rxc_rdy, irq;
  logic [CW_W-1:0] rxc_data;
  logic [STAT_W-1:0] stat;

  int checks = 0;
  int errors = 0;
  int exp_free = DEPTH;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfsr_top #(.DEPTH(DEPTH), .WM_W(WM_W), .CW_W(CW_W), .STAT_W(STAT_W)) i_sfsr_top (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .wm(wm),
    .tx_push(tx_push), .tx_pop(tx_pop), .dma_wr(dma_wr),
    .rxc_load(rxc_load), .rxc_word(rxc_word), .rxc_rd(rxc_rd),
    .ie_tx(ie_tx), .ie_rx(ie_rx), .tx_free(tx_free), .tx_req(tx_req),
    .rxc_data(rxc_data), .rxc_rdy(rxc_rdy), .stat(stat), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1 tx_free", int'(tx_free), DEPTH);
    chk("R1 tx_req", int'(tx_req), 0);
    chk("R1 rxc_rdy", int'(rxc_rdy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rxc_data", int'(rxc_data), 0);
    chk("R1 stat", int'(stat), 0);
    rst = 1'b0;
  endtask

  task automatic t_level();
    wm = 4'd4; tx_en = 1'b1;
    step();
    chk("R3 free 16 above wm 4", int'(tx_req), 1);
    for (int i = 1; i <= 12; i++) begin
      tx_push = 1'b1;
      step();
      exp_free--;
      chk("R2 free after push", int'(tx_free), exp_free);
      chk("R3 req vs wm", int'(tx_req), (exp_free > 4) ? 1 : 0);
    end
    tx_push = 1'b1; tx_pop = 1'b1;
    step();
    chk("R2 push with pop", int'(tx_free), exp_free);
    tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic t_dma();
    tx_pop = 1'b1; dma_wr = 1'b1;
    step();
    exp_free++;
    chk("R4 free after pop", int'(tx_free), exp_free);
    chk("R4 dma with pop clears", int'(tx_req), 0);
    tx_pop = 1'b0; dma_wr = 1'b0;
    step();
    chk("R4 request returns", int'(tx_req), 1);
    dma_wr = 1'b1;
    step();
    chk("R4 lone dma clears", int'(tx_req), 0);
    dma_wr = 1'b0;
    step();
    chk("R4 request back", int'(tx_req), 1);
    tx_push = 1'b1; dma_wr = 1'b1;
    step();
    exp_free--;
    dma_wr = 1'b0; tx_push = 1'b0;
    step();
    chk("R4 no return below wm", int'(tx_req), 0);
    tx_pop = 1'b1;
    step();
    exp_free++;
    tx_pop = 1'b0;
    chk("R3 pop above wm", int'(tx_req), 1);
  endtask

  task automatic t_wm();
    wm = 4'd5;
    step();
    chk("R3 equal to wm", int'(tx_req), 0);
    wm = 4'd15;
    step();
    chk("R3 high wm", int'(tx_req), 0);
    wm = 4'd0;
    step();
    chk("R3 zero wm", int'(tx_req), 1);
  endtask

  task automatic t_enable();
    tx_en = 1'b0;
    step();
    chk("R5 disabled", int'(tx_req), 0);
    chk("R5 free kept", int'(tx_free), exp_free);
    tx_en = 1'b1;
    step();
    chk("R5 re-enabled", int'(tx_req), 1);
  endtask

  task automatic t_rx();
    rx_en = 1'b1; rxc_load = 1'b1; rxc_word = 16'hA5C3;
    step();
    chk("R6 rdy set", int'(rxc_rdy), 1);
    chk("R6 data", int'(rxc_data), 16'hA5C3);
    rxc_word = 16'h1234;
    step();
    chk("R6 overwrite data", int'(rxc_data), 16'h1234);
    chk("R6 overwrite rdy", int'(rxc_rdy), 1);
    rxc_load = 1'b0; rxc_rd = 1'b1;
    step();
    chk("R7 read clears", int'(rxc_rdy), 0);
    chk("R7 data kept", int'(rxc_data), 16'h1234);
    rxc_load = 1'b1; rxc_word = 16'h0F0F;
    step();
    chk("R7 load wins", int'(rxc_rdy), 1);
    chk("R7 load wins data", int'(rxc_data), 16'h0F0F);
    rxc_load = 1'b0; rxc_rd = 1'b0; rx_en = 1'b0;
    step();
    chk("R8 disable clears rdy", int'(rxc_rdy), 0);
    rxc_load = 1'b1; rxc_word = 16'hDEAD;
    step();
    chk("R8 load ignored rdy", int'(rxc_rdy), 0);
    chk("R8 load ignored data", int'(rxc_data), 16'h0F0F);
    rxc_load = 1'b0; rx_en = 1'b1;
  endtask

  task automatic t_irq();
    ie_tx = 1'b0; ie_rx = 1'b0;
    step();
    chk("R9 masked", int'(irq), 0);
    ie_tx = 1'b1;
    step();
    chk("R9 tx enabled", int'(irq), 1);
    ie_tx = 1'b0;
    step();
    chk("R9 tx masked again", int'(irq), 0);
    ie_rx = 1'b1; rxc_load = 1'b1; rxc_word = 16'h0042;
    step();
    chk("R9 rdy set", int'(rxc_rdy), 1);
    chk("R9 irq lags", int'(irq), 0);
    chk("R10 stat both", int'(stat), 3);
    rxc_load = 1'b0;
    step();
    chk("R9 irq follows", int'(irq), 1);
    rxc_rd = 1'b1;
    step();
    chk("R9 irq held one cycle", int'(irq), 1);
    chk("R10 stat tx only", int'(stat), 1);
    rxc_rd = 1'b0;
    step();
    chk("R9 irq drops", int'(irq), 0);
    tx_en = 1'b0;
    step();
    chk("R10 stat zero", int'(stat), 0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_dma();
    t_wm();
    t_enable();
    t_rx();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule